// File: doc/BRIEF.md
# Paged Data-Memory Address Generator

This block builds the data-RAM address from two registers: an 8-bit page pointer that picks one of 256 pages, and a 4-bit index that picks one of the 16 entries inside that page. Sixteen entries hold one floating-point value, so software can treat each page as one object and walk through its digits with the index. Both registers load from the 8-bit system bus. The index can also step forward by one or by two without using the bus, which saves a bus cycle when code steps through memory.

The same register pair also serves as a pointer into program ROM. While the program counter's output is disabled, the block drives the ROM address. Its upper bits are held high, which matches a pulled-up bus. This lets code fetch constants through the pointer. The data address is 12 bits wide, so only the lower 4K of an 8K RAM can be reached.

Top module: `paged_addr_gen`

## Requirements
- R1: While rst_ni is low, the index and the page pointer are both 0, so ram_addr_o reads 0.
- R2: ram_addr_o carries the page pointer in bits 11:4 and the index in bits 3:0.
- R3: With idx_load_i high at a rising clock edge, the index takes bus_i[3:0]. Bus bits 7:4 have no effect on the index.
- R4: With page_load_i high at a rising clock edge, the page pointer takes all of bus_i[7:0].
- R5: With idx_inc_i high and no load, the index rises by one at the clock edge. It wraps from 15 to 0 and leaves the page pointer unchanged.
- R6: With idx_inc2_i high and no load, the index rises by two, wrapping modulo 16 (14 to 0, 15 to 1). This applies whether or not idx_inc_i is also high.
- R7: When idx_load_i is high in the same cycle as idx_inc_i or idx_inc2_i, the load wins.
- R8: With no load and no increment, the index and the page pointer keep their values.
- R9: While pc_oe_i is high, rom_addr_o equals pc_addr_i.
- R10: While pc_oe_i is low, rom_addr_o is {3'b111, page pointer, index}.
- R11: A page load and an index load in the same cycle both take effect from the same bus byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_i | input | 8 | System bus data |
| idx_load_i | input | 1 | Load the index from bus_i[3:0] |
| page_load_i | input | 1 | Load the page pointer from bus_i |
| idx_inc_i | input | 1 | Step the index by one |
| idx_inc2_i | input | 1 | Step the index by two |
| pc_oe_i | input | 1 | Program counter drives the ROM address |
| pc_addr_i | input | 15 | Program counter address |
| ram_addr_o | output | 12 | Data-RAM address |
| rom_addr_o | output | 15 | Program-ROM address |

## Verification
The assertions assume that the control inputs are stable and known at every rising edge once reset is released. They also assume that any mix of load and increment strobes may appear together, so the precedence checks cover those overlaps. The stimulus changes every input only on the falling edge. It drives the overlapping strobe cases on purpose, and it toggles pc_oe_i in the same cycles as register updates so that the ROM override is seen against fresh register values.

// File: rtl/paged_addr_pkg.sv
package paged_addr_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_ONE  = 2'd1,
    STEP_TWO  = 2'd2
  } idx_step_e;

  // the double step takes precedence over the single step
  function automatic idx_step_e pick_step(input logic inc1, input logic inc2);
    if (inc2) return STEP_TWO;
    if (inc1) return STEP_ONE;
    return STEP_HOLD;
  endfunction
endpackage

// File: rtl/addr_idx_ctr.sv
module addr_idx_ctr
  import paged_addr_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [IDX_W-1:0] load_val_i,
  input  idx_step_e        step_i,
  output logic [IDX_W-1:0] idx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o <= '0;
    end else if (load_i) begin
      idx_o <= load_val_i;
    end else begin
      unique case (step_i)
        STEP_ONE: idx_o <= idx_o + IDX_W'(1);
        STEP_TWO: idx_o <= idx_o + IDX_W'(2);
        default:  idx_o <= idx_o;
      endcase
    end
  end
endmodule

// File: rtl/addr_page_reg.sv
module addr_page_reg #(
  parameter int PAGE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [PAGE_W-1:0] load_val_i,
  output logic [PAGE_W-1:0] page_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     page_o <= '0;
    else if (load_i) page_o <= load_val_i;
  end
endmodule

// File: rtl/addr_rom_mux.sv
module addr_rom_mux #(
  parameter int ADDR_W = 12,
  parameter int ROM_AW = 15
) (
  input  logic              pc_oe_i,
  input  logic [ROM_AW-1:0] pc_addr_i,
  input  logic [ADDR_W-1:0] ptr_addr_i,
  output logic [ROM_AW-1:0] rom_addr_o
);
  logic [ROM_AW-1:0] ptr_ext;

  generate
    if (ROM_AW > ADDR_W) begin : g_fill
      localparam int FILL_W = ROM_AW - ADDR_W;
      // undriven upper lines float high
      assign ptr_ext = {{FILL_W{1'b1}}, ptr_addr_i};
    end else begin : g_trunc
      assign ptr_ext = ptr_addr_i[ROM_AW-1:0];
    end
  endgenerate

  assign rom_addr_o = pc_oe_i ? pc_addr_i : ptr_ext;
endmodule

// File: rtl/paged_addr_gen.sv
module paged_addr_gen
  import paged_addr_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int PAGE_W = 8,
  parameter int BUS_W  = 8,
  parameter int ROM_AW = 15
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [BUS_W-1:0]          bus_i,
  input  logic                      idx_load_i,
  input  logic                      page_load_i,
  input  logic                      idx_inc_i,
  input  logic                      idx_inc2_i,
  input  logic                      pc_oe_i,
  input  logic [ROM_AW-1:0]         pc_addr_i,
  output logic [IDX_W+PAGE_W-1:0]   ram_addr_o,
  output logic [ROM_AW-1:0]         rom_addr_o
);
  localparam int ADDR_W = IDX_W + PAGE_W;

  logic [IDX_W-1:0]  idx_q;
  logic [PAGE_W-1:0] page_q;
  idx_step_e         step;

  assign step = pick_step(idx_inc_i, idx_inc2_i);

  addr_idx_ctr #(.IDX_W(IDX_W)) i_idx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (idx_load_i),
    .load_val_i (bus_i[IDX_W-1:0]),
    .step_i     (step),
    .idx_o      (idx_q)
  );

  addr_page_reg #(.PAGE_W(PAGE_W)) i_page (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (page_load_i),
    .load_val_i (bus_i[PAGE_W-1:0]),
    .page_o     (page_q)
  );

  assign ram_addr_o = {page_q, idx_q};

  addr_rom_mux #(.ADDR_W(ADDR_W), .ROM_AW(ROM_AW)) i_rom_mux (
    .pc_oe_i    (pc_oe_i),
    .pc_addr_i  (pc_addr_i),
    .ptr_addr_i (ram_addr_o),
    .rom_addr_o (rom_addr_o)
  );
endmodule

// File: rtl/paged_addr_gen_chk.sv
module paged_addr_gen_chk #(
  parameter int IDX_W  = 4,
  parameter int PAGE_W = 8,
  parameter int BUS_W  = 8,
  parameter int ROM_AW = 15
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [BUS_W-1:0]        bus_i,
  input logic                    idx_load_i,
  input logic                    page_load_i,
  input logic                    idx_inc_i,
  input logic                    idx_inc2_i,
  input logic                    pc_oe_i,
  input logic [ROM_AW-1:0]       pc_addr_i,
  input logic [IDX_W+PAGE_W-1:0] ram_addr_o,
  input logic [ROM_AW-1:0]       rom_addr_o
);
  localparam int ADDR_W = IDX_W + PAGE_W;

  always_comb begin
    if (!rst_ni) a_r1_reset_zero: assert (ram_addr_o == '0);
  end

  a_r3_idx_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_load_i |=> ram_addr_o[IDX_W-1:0] == $past(bus_i[IDX_W-1:0]));

  a_r4_page_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_load_i |=> ram_addr_o[ADDR_W-1:IDX_W] == $past(bus_i[PAGE_W-1:0]));

  a_r5_inc_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idx_load_i && idx_inc_i && !idx_inc2_i) |=>
      ram_addr_o[IDX_W-1:0] == IDX_W'($past(ram_addr_o[IDX_W-1:0]) + IDX_W'(1)));

  a_r6_inc_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idx_load_i && idx_inc2_i) |=>
      ram_addr_o[IDX_W-1:0] == IDX_W'($past(ram_addr_o[IDX_W-1:0]) + IDX_W'(2)));

  a_r5_page_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !page_load_i |=> $stable(ram_addr_o[ADDR_W-1:IDX_W]));

  a_r8_idx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idx_load_i && !idx_inc_i && !idx_inc2_i) |=> $stable(ram_addr_o[IDX_W-1:0]));

  a_r9_pc_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_oe_i |-> rom_addr_o == pc_addr_i);

  a_r10_ptr_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pc_oe_i |-> rom_addr_o[ADDR_W-1:0] == ram_addr_o);
endmodule

bind paged_addr_gen paged_addr_gen_chk #(
  .IDX_W(IDX_W), .PAGE_W(PAGE_W), .BUS_W(BUS_W), .ROM_AW(ROM_AW)
) i_chk (.*);

// File: tb/test_paged_addr_gen.sv
module test_paged_addr_gen;
  localparam time CLK_PERIOD = 10ns;

  typedef struct {
    logic [11:0] ram;
    logic [14:0] rom;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus = '0;
  logic        idx_load = 1'b0, page_load = 1'b0, inc1 = 1'b0, inc2 = 1'b0;
  logic        pc_oe = 1'b0;
  logic [14:0] pc_addr = '0;
  logic [11:0] ram_addr;
  logic [14:0] rom_addr;

  int   checks = 0, failures = 0;
  bit   done = 1'b0;
  exp_t sb_q[$];
  logic [3:0] m_idx = '0;
  logic [7:0] m_page = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  paged_addr_gen i_paged_addr_gen (
    .clk_i(clk), .rst_ni(rst_n), .bus_i(bus),
    .idx_load_i(idx_load), .page_load_i(page_load),
    .idx_inc_i(inc1), .idx_inc2_i(inc2),
    .pc_oe_i(pc_oe), .pc_addr_i(pc_addr),
    .ram_addr_o(ram_addr), .rom_addr_o(rom_addr)
  );

  task automatic chk(input string tag, input logic [14:0] act, input logic [14:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic il, input logic pl, input logic i1, input logic i2,
                       input logic [7:0] b, input logic oe, input logic [14:0] pc,
                       input string tag);
    exp_t e;
    @(negedge clk);
    idx_load = il; page_load = pl; inc1 = i1; inc2 = i2;
    bus = b; pc_oe = oe; pc_addr = pc;
    if (il)      m_idx = b[3:0];
    else if (i2) m_idx = m_idx + 4'd2;
    else if (i1) m_idx = m_idx + 4'd1;
    if (pl) m_page = b;
    e.ram = {m_page, m_idx};
    e.rom = oe ? pc : {3'b111, m_page, m_idx};
    e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        chk({e.tag, " ram"}, {3'b000, ram_addr}, {3'b000, e.ram});
        chk({e.tag, " rom"}, rom_addr, e.rom);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // strobes active during reset must not matter
    idx_load = 1'b1; page_load = 1'b1; bus = 8'hFF;
    #(CLK_PERIOD * 3);
    chk("R1 reset ram", {3'b000, ram_addr}, 15'h0000);
    chk("R10 reset rom", rom_addr, 15'h7000);
    @(negedge clk);
    idx_load = 1'b0; page_load = 1'b0;
    rst_n = 1'b1;

    drive(0, 1, 0, 0, 8'h3C, 0, 15'h0000, "R4 page load");
    drive(1, 0, 0, 0, 8'hA5, 0, 15'h0000, "R3 idx load hi bits ignored");
    drive(0, 0, 0, 0, 8'hFF, 0, 15'h0000, "R8 hold");
    drive(0, 0, 1, 0, 8'h00, 0, 15'h0000, "R5 inc one");
    drive(1, 0, 0, 0, 8'h0F, 0, 15'h0000, "R3 idx to 15");
    drive(0, 0, 1, 0, 8'h00, 0, 15'h0000, "R5 wrap 15 to 0 page kept");
    drive(1, 0, 0, 0, 8'h0E, 0, 15'h0000, "R3 idx to 14");
    drive(0, 0, 0, 1, 8'h00, 0, 15'h0000, "R6 inc two wrap 14 to 0");
    drive(1, 0, 0, 0, 8'h0F, 0, 15'h0000, "R3 idx to 15");
    drive(0, 0, 1, 1, 8'h00, 0, 15'h0000, "R6 both inc 15 to 1");
    drive(1, 0, 1, 0, 8'h09, 0, 15'h0000, "R7 load beats inc");
    drive(1, 0, 1, 1, 8'h02, 0, 15'h0000, "R7 load beats inc2");
    drive(1, 1, 0, 0, 8'hD7, 0, 15'h0000, "R11 both loads");
    drive(0, 0, 0, 0, 8'h00, 1, 15'h1234, "R9 pc passthrough");
    drive(0, 0, 1, 0, 8'h00, 1, 15'h7FFF, "R9 pc during inc");
    drive(0, 1, 0, 0, 8'h81, 0, 15'h5555, "R10 pointer drives rom");
    drive(0, 0, 0, 0, 8'h00, 0, 15'h0000, "R2 composition");
    for (int k = 0; k < 20; k++)
      drive(0, 0, 1, 0, 8'h00, k[0], 15'(k * 997), "R5 walk");
    drive(0, 0, 0, 0, 8'h00, 0, 15'h0000, "R8 final hold");

    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule